// File: doc/BRIEF.md
# Preamble and Frame Start Generator

This block produces the serial bits that go out ahead of the frame data on a link that runs one of two protocols. A mode input picks the protocol. A value of 0 selects a collision-detect link. A value of 1 selects a flagged, HDLC-style link. A 2-bit length code sets the number of preamble bits. The preamble body alternates 1 and 0 and begins with 1.

On the collision-detect link, the last two bits of the preamble are a pair of ones that marks the start of the frame. These two bits count toward the preamble length. On the flagged link, a full 0x7E flag byte follows the preamble and does not count toward its length. Line coding is left to later stages.

A start request takes a snapshot of the configuration. After that, the block moves one bit forward each time it sees a bit-tick. When the last bit has gone out, it gives a one-cycle done strobe so the data path can take over. A start that asks for length code 00 on the collision-detect link is refused with an error strobe, and no bits are sent.

The control state machine has three states:
- `S_IDLE`: waiting for a start request.
- `S_PRE`: sending the alternating body and, on the collision-detect link, the marker.
- `S_FLAG`: sending the flag byte.

Its transitions are:
- IDLE to PRE: a start with a nonzero length.
- IDLE to FLAG: a start on the flagged link with length 0.
- IDLE to IDLE with error: a start on the collision-detect link with code 00.
- PRE to PRE: a tick that is not on the last bit.
- PRE to FLAG: a tick on the last bit, flagged link.
- PRE to IDLE with done: a tick on the last bit, collision-detect link.
- FLAG to IDLE with done: a tick on the eighth flag bit.

Top module: `preamble_gen`

## Requirements
- R1: While reset is held and right after it is released, tx_bit, tx_active, done and err are all 0.
- R2: The length code sets the preamble length L: 00 gives 0 bits, 01 gives 8, 10 gives 32 and 11 gives 64. The frame holds exactly L bits on the collision-detect link and L+8 bits on the flagged link.
- R3: Preamble bit k (counting from 0) is 1 when k is even and 0 when k is odd, except for the marker bits described in R4.
- R4: On the collision-detect link (cfg_flagged=0), bits L-2 and L-1 of the preamble are both 1. They are the start marker and count toward L.
- R5: On the flagged link (cfg_flagged=1), the L preamble bits are followed by the flag 0x7E, sent least significant bit first: 0,1,1,1,1,1,1,0. With code 00, only the flag is sent.
- R6: A start with cfg_flagged=0 and code 00 makes err high for exactly the one cycle after the start. No bit is sent, tx_active stays 0 and done stays 0.
- R7: While tx_active is high, tx_bit holds its value. It moves to the next bit only at a clock edge where tick was high.
- R8: done is high for exactly one cycle. That cycle follows the tick that took the last bit, and tx_active is already 0 in it.
- R9: The configuration is captured when a start is accepted. Start requests and changes to the configuration while a frame is in progress have no effect on that frame.
- R10: tick has no effect while idle: tx_bit stays 0 and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_flagged | input | 1 | Protocol select: 1 for the flagged link, 0 for the collision-detect link |
| cfg_len | input | 2 | Preamble length code |
| start | input | 1 | Frame start request, sampled while idle |
| tick | input | 1 | Bit-time enable; the current bit is taken at this edge |
| tx_bit | output | 1 | Serial bit currently presented |
| tx_active | output | 1 | High while a preamble or flag bit is presented |
| done | output | 1 | One-cycle strobe after the last bit |
| err | output | 1 | One-cycle strobe when a start is refused |

## Verification
The hardest case to reach from the ports is a start request, together with a changed configuration, arriving while a frame is in progress. If the snapshot or the idle-only start gating failed, the bit stream would bend partway through the frame. To get there, the bench holds tick low for a few cycles in the middle of a frame. It then pulses start with the opposite protocol and a different code, and keeps comparing every later bit against the sequence the original configuration implies. The two frame-end paths are also driven, with and without gaps between ticks. These are the marker that ends inside the length and the flag byte that is appended after it.

// File: rtl/pg_pkg.sv
package pg_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PRE  = 2'd1,
        S_FLAG = 2'd2
    } pg_state_t;
endpackage

// File: rtl/pg_count.sv
module pg_count #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (inc)
            idx <= idx + 1'b1;
    end
endmodule

// File: rtl/pg_pattern.sv
module pg_pattern
    import pg_pkg::*;
#(
    parameter int         CNT_W     = 7,
    parameter int         FLAG_BITS = 8,
    parameter logic [7:0] FLAG_PAT  = 8'h7E
) (
    input  pg_state_t        state,
    input  logic [CNT_W-1:0] idx,
    input  logic [CNT_W-1:0] plen,
    input  logic             flagged,
    output logic             bit_o,
    output logic             last_o
);
    localparam int FI_W = $clog2(FLAG_BITS);
    localparam logic [CNT_W-1:0] FLAG_LAST = CNT_W'(FLAG_BITS - 1);

    logic [CNT_W-1:0] pre_last;
    logic [CNT_W-1:0] mark_first;

    assign pre_last   = plen - 1'b1;
    assign mark_first = plen - 2'd2;

    always_comb begin
        bit_o  = 1'b0;
        last_o = 1'b0;
        unique case (state)
            S_PRE: begin
                if (!flagged && idx >= mark_first)
                    bit_o = 1'b1;
                else
                    bit_o = ~idx[0];
                last_o = (idx == pre_last);
            end
            S_FLAG: begin
                bit_o  = FLAG_PAT[idx[FI_W-1:0]];
                last_o = (idx == FLAG_LAST);
            end
            default: begin
                bit_o  = 1'b0;
                last_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
    import pg_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int LEN1  = 8,
    parameter int LEN2  = 32,
    parameter int LEN3  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             cfg_flagged,
    input  logic [1:0]       cfg_len,
    input  logic             last,
    output pg_state_t        state,
    output logic             mode_q,
    output logic [CNT_W-1:0] plen_q,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             done,
    output logic             err
);
    pg_state_t        nxt;
    logic [CNT_W-1:0] req_len;
    logic             reject;
    logic             accept;

    function automatic logic [CNT_W-1:0] len_of(input logic [1:0] code);
        logic [CNT_W-1:0] r;
        unique case (code)
            2'b00: r = '0;
            2'b01: r = CNT_W'(LEN1);
            2'b10: r = CNT_W'(LEN2);
            2'b11: r = CNT_W'(LEN3);
        endcase
        return r;
    endfunction

    assign req_len = len_of(cfg_len);
    assign reject  = (state == S_IDLE) && start && !cfg_flagged && (cfg_len == 2'b00);
    assign accept  = (state == S_IDLE) && start && !reject;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (accept) nxt = (req_len != '0) ? S_PRE : S_FLAG;
            S_PRE:  if (tick && last) nxt = mode_q ? S_FLAG : S_IDLE;
            S_FLAG: if (tick && last) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign cnt_clr = (state != nxt);
    assign cnt_inc = tick && (state != S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // registered outputs and configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            err    <= 1'b0;
            mode_q <= 1'b0;
            plen_q <= '0;
        end else begin
            done <= (state != S_IDLE) && (nxt == S_IDLE);
            err  <= reject;
            if (accept) begin
                mode_q <= cfg_flagged;
                plen_q <= req_len;
            end
        end
    end

    // R6
    refused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (state == S_IDLE && !done));

    // R5
    flag_only_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FLAG) |-> mode_q);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != S_IDLE) |-> ($stable(mode_q) && $stable(plen_q)));
endmodule

// File: rtl/preamble_gen.sv
module preamble_gen
    import pg_pkg::*;
#(
    parameter int         LEN1      = 8,
    parameter int         LEN2      = 32,
    parameter int         LEN3      = 64,
    parameter int         FLAG_BITS = 8,
    parameter logic [7:0] FLAG_PAT  = 8'h7E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_flagged,
    input  logic [1:0] cfg_len,
    input  logic       start,
    input  logic       tick,
    output logic       tx_bit,
    output logic       tx_active,
    output logic       done,
    output logic       err
);
    localparam int MAXL  = (LEN3 > FLAG_BITS) ? LEN3 : FLAG_BITS;
    localparam int CNT_W = $clog2(MAXL) + 1;

    pg_state_t        state;
    logic             mode_q;
    logic [CNT_W-1:0] plen_q;
    logic [CNT_W-1:0] idx;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             last;

    pg_ctrl #(.CNT_W(CNT_W), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .cfg_flagged(cfg_flagged), .cfg_len(cfg_len), .last(last),
        .state(state), .mode_q(mode_q), .plen_q(plen_q),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .done(done), .err(err)
    );

    pg_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .idx(idx)
    );

    pg_pattern #(.CNT_W(CNT_W), .FLAG_BITS(FLAG_BITS), .FLAG_PAT(FLAG_PAT)) u_pattern (
        .state(state), .idx(idx), .plen(plen_q), .flagged(mode_q),
        .bit_o(tx_bit), .last_o(last)
    );

    assign tx_active = (state != S_IDLE);

    // R4
    marker_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(tx_bit) == !mode_q));

    // R7
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_active) && !$past(tick)) |-> (tx_active && $stable(tx_bit)));

    // R8
    done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tx_active && $past(tx_active)));
endmodule

// File: tb/preamble_gen_test.sv
`timescale 1ns/1ps
module preamble_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_flagged = 1'b0;
    logic [1:0] cfg_len = 2'b00;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic       tx_bit, tx_active, done, err;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    preamble_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_flagged(cfg_flagged), .cfg_len(cfg_len),
        .start(start), .tick(tick), .tx_bit(tx_bit), .tx_active(tx_active),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'b00: return 0;
            2'b01: return 8;
            2'b10: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic bit exp_bit(input bit fl, input int len, input int k);
        logic [7:0] flag = 8'h7E;
        if (k < len) begin
            if (!fl && k >= len - 2) return 1'b1;
            return (k % 2 == 0);
        end
        return flag[k - len];
    endfunction

    // R2 R3 R4 R5 R7 R8 R9: one full frame with every bit compared
    task automatic run_frame(input bit fl, input logic [1:0] code, input int gap,
                             input bit disturb, input string tag);
        int len = len_of(code);
        int total = fl ? len + 8 : len;
        cfg_flagged = fl;
        cfg_len = code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < total; k++) begin
            for (int g = 0; g < gap; g++) begin
                chk(tx_active && tx_bit == exp_bit(fl, len, k), "R7 hold", tx_bit, exp_bit(fl, len, k));
                if (disturb && k == 3 && g == 0) begin
                    start = 1'b1;
                    cfg_flagged = ~fl;
                    cfg_len = ~code;
                end
                @(negedge clk);
                start = 1'b0;
            end
            chk(tx_active && !done && tx_bit == exp_bit(fl, len, k), tag, tx_bit, exp_bit(fl, len, k));
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
        chk(done && !tx_active, "R8 done at end", done, 1);
        @(negedge clk);
        chk(!done && !tx_active, "R8 done single", done, 0);
    endtask

    // R6
    task automatic refuse_test();
        cfg_flagged = 1'b0;
        cfg_len = 2'b00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err && !tx_active && !done, "R6 err raised", err, 1);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk(!err && !tx_active && !done, "R6 err single", err, 0);
    endtask

    // R10
    task automatic idle_tick_test();
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        chk(!tx_bit && !tx_active && !done, "R10 idle tick", tx_bit, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!tx_bit && !tx_active && !done && !err, "R1 in reset", tx_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_bit && !tx_active && !done && !err, "R1 after reset", tx_active, 0);
        idle_tick_test();
        run_frame(1'b0, 2'b01, 0, 1'b0, "R2 R3 R4 collision 8");
        run_frame(1'b0, 2'b10, 1, 1'b0, "R2 R3 R4 collision 32");
        run_frame(1'b0, 2'b11, 0, 1'b0, "R2 R3 R4 collision 64");
        run_frame(1'b1, 2'b00, 0, 1'b0, "R5 flag only");
        run_frame(1'b1, 2'b01, 2, 1'b0, "R2 R3 R5 flagged 8");
        run_frame(1'b1, 2'b11, 0, 1'b0, "R2 R3 R5 flagged 64");
        refuse_test();
        run_frame(1'b1, 2'b10, 2, 1'b1, "R9 flagged 32 disturbed");
        run_frame(1'b0, 2'b01, 2, 1'b1, "R9 collision 8 disturbed");
        idle_tick_test();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8 actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule